// File: doc/BRIEF.md
# Serial Audio Transmit Serializer

This block turns parallel audio samples into a serial bit stream. The stream is framed by a word-select line that changes level once per slot. An external divider supplies a one-cycle bit strobe `bclk_en`. On each strobe the block moves one bit position forward and updates its serial data, its word-select and its outgoing bit-clock pulse `sck_en`. Each sample is sent most significant bit first, and its length in bits is set by `cfg_wlen`. Any bit positions in the slot after the sample are filled with the padding level.

Samples arrive on a valid/ready stream. `s_ready` is high only in the strobe cycle that opens a new slot. A sample is taken in that cycle when `s_valid` is also high. The producer may hold `s_valid` high for as long as it likes, but a new sample has to be waiting when the slot starts. If no sample is waiting, that slot carries only padding and `underflow` stays high until the next slot starts. Data may start one bit period after the word-select edge or in the same bit period. In compressed mode with burst enabled, the outgoing bit-clock pulses are sent only for bits that belong to a sample. Mute forces the serial line low.

Top module: `audio_tx_serializer`

## Requirements
- R1: While `rst_n` is low and after its release, before any strobe: `ser_data`=0, `ser_ws`=1, `sck_en`=0, `underflow`=0 and `s_ready`=0.
- R2: Strobe k after reset (k counted from 1) leaves `ser_ws` at ((k-1)/SLOT_BITS) mod 2. The first strobe therefore drives it low, and it changes only in the cycle after a strobe.
- R3: With `cfg_nodelay`=0, the slot's bit position p equals (strobe count within the word-select period − 1) mod SLOT_BITS. The first sample bit comes out one bit period after the word-select change.
- R4: With `cfg_nodelay`=1, the slot's bit position equals the strobe count within the word-select period. The first sample bit comes out in the same bit period as the word-select change.
- R5: For p < `cfg_wlen`, `ser_data` is bit (`cfg_wlen`−1−p) of the sample (its low `cfg_wlen` bits, MSB first). It is updated in the cycle after each strobe.
- R6: For p ≥ `cfg_wlen`, `ser_data` equals `cfg_pad`.
- R7: `s_ready` is high only in a strobe cycle whose new bit position is 0. `s_valid` in any other cycle has no effect on the data sent.
- R8: If `s_valid` is low when the slot opens, the whole slot is padding and `underflow` is 1 from the next cycle until the next slot opens.
- R9: In the cycle after each strobe, `sck_en` pulses for exactly one cycle. When both `cfg_compress` and `cfg_burst` are 1, the pulse appears only for in-sample bits, so an underflow slot has none.
- R10: When `cfg_compress`=0, `cfg_burst` has no effect on `sck_en`.
- R11: If `cfg_mute`=1 at a strobe, `ser_data` is 0 afterwards, whatever `cfg_pad` is.
- R12: `cfg_compress`=1 requires `cfg_nodelay`=1. The pairing of compressed mode with a one-period delay is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | One-cycle bit-period strobe |
| s_valid | input | 1 | Sample offered |
| s_data | input | SAMPLE_W | Sample, right-justified |
| s_ready | output | 1 | Sample taken this cycle if valid |
| cfg_nodelay | input | 1 | 1: no delay between word-select and data |
| cfg_compress | input | 1 | Compressed mode |
| cfg_burst | input | 1 | Burst clock gating (compressed only) |
| cfg_mute | input | 1 | Force serial data low |
| cfg_pad | input | 1 | Level for bits past the sample |
| cfg_wlen | input | $clog2(SAMPLE_W+1) | Sample length in bits, 1..SAMPLE_W |
| ser_data | output | 1 | Serial data |
| ser_ws | output | 1 | Word-select |
| sck_en | output | 1 | Outgoing bit-clock pulse |
| underflow | output | 1 | Current slot had no sample |

## Verification
The assertions assume four things about the inputs. `bclk_en` is a single-cycle pulse with at least one idle cycle between pulses. `cfg_wlen` is between 1 and SAMPLE_W. The configuration never pairs compressed mode with the delayed alignment. Configuration changes only while reset is held. The stimulus keeps to all four: it changes configuration only during reset, fires a strobe every third cycle and skips the illegal mode pairing. It also holds `s_valid` high with garbage data in cycles where no slot opens, to show that such data is never taken.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  typedef struct packed {
    logic nodelay;
    logic compress;
    logic burst;
    logic mute;
    logic pad;
  } atx_cfg_t;

  function automatic logic burst_active(atx_cfg_t c);
    return c.compress & c.burst;
  endfunction
endpackage

// File: rtl/atx_slot_timer.sv
module atx_slot_timer #(
  parameter int SLOT_BITS = 16,
  parameter int POS_W     = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             no_delay,
  output logic             ws,
  output logic [POS_W-1:0] pos_nxt,
  output logic             slot_open
);
  localparam logic [POS_W-1:0] LAST = POS_W'(SLOT_BITS - 1);

  logic [POS_W-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
    if (no_delay) pos_nxt = cnt_nxt;
    else          pos_nxt = (cnt_nxt == '0) ? LAST : cnt_nxt - 1'b1;
    slot_open = strobe && (pos_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= LAST;
      ws  <= 1'b1;
    end else if (strobe) begin
      cnt <= cnt_nxt;
      if (cnt_nxt == '0) ws <= ~ws;
    end
  end

  // R2
  ws_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe) |-> $stable(ws));
endmodule

// File: rtl/atx_sample_hold.sv
module atx_sample_hold #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_open,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  output logic                eff_has,
  output logic [SAMPLE_W-1:0] eff_word,
  output logic                underflow
);
  logic                has;
  logic [SAMPLE_W-1:0] word;

  always_comb begin
    in_ready = slot_open;
    eff_has  = slot_open ? in_valid : has;
    eff_word = slot_open ? in_data  : word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has       <= 1'b0;
      word      <= '0;
      underflow <= 1'b0;
    end else if (slot_open) begin
      has       <= in_valid;
      word      <= in_data;
      underflow <= ~in_valid;
    end
  end

  // R8
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_open) |-> $stable(underflow));
endmodule

// File: rtl/atx_bit_picker.sv
module atx_bit_picker
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int POS_W    = 4,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  atx_cfg_t            cfg,
  input  logic [LEN_W-1:0]    wlen,
  input  logic [POS_W-1:0]    pos,
  input  logic                eff_has,
  input  logic [SAMPLE_W-1:0] eff_word,
  output logic                ser_data,
  output logic                sck_en
);
  localparam int CW    = POS_W + 1;
  localparam int SEL_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

  logic [CW-1:0] wl, p, idx;
  logic          in_word, bit_val, gate_ok;

  always_comb begin
    wl      = CW'(wlen);
    p       = CW'(pos);
    idx     = wl - p - 1'b1;
    in_word = eff_has && (p < wl);
    bit_val = in_word ? eff_word[idx[SEL_W-1:0]] : cfg.pad;
    gate_ok = !burst_active(cfg) || in_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_data <= 1'b0;
      sck_en   <= 1'b0;
    end else begin
      sck_en <= strobe && gate_ok;
      if (strobe) ser_data <= bit_val && !cfg.mute;
    end
  end

  // R11
  mute_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg.mute) && $past(strobe)) |-> !ser_data);
  // R9
  sck_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_en |-> $past(strobe));
endmodule

// File: rtl/audio_tx_serializer.sv
module audio_tx_serializer
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_BITS = 16,
  parameter int LEN_W     = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_en,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  input  logic                cfg_nodelay,
  input  logic                cfg_compress,
  input  logic                cfg_burst,
  input  logic                cfg_mute,
  input  logic                cfg_pad,
  input  logic [LEN_W-1:0]    cfg_wlen,
  output logic                ser_data,
  output logic                ser_ws,
  output logic                sck_en,
  output logic                underflow
);
  localparam int POS_W = $clog2(SLOT_BITS);

  atx_cfg_t            cfg;
  logic [POS_W-1:0]    pos_nxt;
  logic                slot_open, eff_has;
  logic [SAMPLE_W-1:0] eff_word;

  assign cfg = '{nodelay: cfg_nodelay, compress: cfg_compress, burst: cfg_burst,
                 mute: cfg_mute, pad: cfg_pad};

  atx_slot_timer #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .strobe(bclk_en), .no_delay(cfg_nodelay),
    .ws(ser_ws), .pos_nxt(pos_nxt), .slot_open(slot_open));

  atx_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .slot_open(slot_open), .in_valid(s_valid),
    .in_data(s_data), .in_ready(s_ready), .eff_has(eff_has),
    .eff_word(eff_word), .underflow(underflow));

  atx_bit_picker #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .strobe(bclk_en), .cfg(cfg), .wlen(cfg_wlen),
    .pos(pos_nxt), .eff_has(eff_has), .eff_word(eff_word),
    .ser_data(ser_data), .sck_en(sck_en));

  // R12
  cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_compress |-> cfg_nodelay);
  // R7
  ready_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bclk_en);
  // R9
  burst_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_compress && cfg_burst && s_ready && !s_valid) |-> !sck_en);
endmodule

// File: tb/audio_tx_serializer_test.sv
module audio_tx_serializer_test;
  localparam int SW   = 16;
  localparam int SLOT = 16;
  localparam int NSTB = 50;

  logic clk = 0;
  logic rst_n, bclk_en, s_valid, s_ready;
  logic [SW-1:0] s_data;
  logic cfg_nodelay, cfg_compress, cfg_burst, cfg_mute, cfg_pad;
  logic [4:0] cfg_wlen;
  logic ser_data, ser_ws, sck_en, underflow;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_tx_serializer #(.SAMPLE_W(SW), .SLOT_BITS(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .cfg_nodelay(cfg_nodelay),
    .cfg_compress(cfg_compress), .cfg_burst(cfg_burst), .cfg_mute(cfg_mute),
    .cfg_pad(cfg_pad), .cfg_wlen(cfg_wlen), .ser_data(ser_data),
    .ser_ws(ser_ws), .sck_en(sck_en), .underflow(underflow));

  function automatic logic [SW-1:0] pat(int j);
    return 16'hB4E1 ^ SW'(j * 16'h2F9D);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_cfg(bit nd, bit cp, bit bu, bit mu, bit pd, int wl);
    int loads = 0;
    bit has = 0;
    logic [SW-1:0] word = '0;
    bit uf = 0;
    // R12: the bench flags compressed mode paired with delayed alignment
    check("R12", {31'd0, cp & ~nd}, 32'd0);
    @(negedge clk);
    rst_n = 0;
    cfg_nodelay = nd; cfg_compress = cp; cfg_burst = bu;
    cfg_mute = mu; cfg_pad = pd; cfg_wlen = 5'(wl);
    repeat (2) @(negedge clk);
    check("R1", {27'd0, ser_data, ser_ws, sck_en, underflow, s_ready}, 32'b01000);
    rst_n = 1;
    #1;
    check("R1", {27'd0, ser_data, ser_ws, sck_en, underflow, s_ready}, 32'b01000);
    for (int k = 1; k <= NSTB; k++) begin
      int c, pos;
      bit ld, inw, eb, ews, esck;
      string dtag;
      c   = (k - 1) % SLOT;
      pos = nd ? c : (c + SLOT - 1) % SLOT;
      ld  = (pos == 0);
      @(negedge clk);
      bclk_en = 1;
      if (ld) begin
        s_valid = (loads != 1);
        s_data  = pat(loads);
      end else begin
        s_valid = 1;           // R7: not taken outside a slot opening
        s_data  = ~pat(loads + 7);
      end
      #1;
      check("R7", {31'd0, s_ready}, {31'd0, ld});
      if (ld) begin
        has  = (loads != 1);
        word = pat(loads);
        uf   = !has;
        loads++;
      end
      inw = has && (pos < wl);
      eb  = inw ? word[wl - 1 - pos] : pd;
      if (mu) eb = 0;
      ews  = ((k - 1) / SLOT) % 2;
      esck = !(cp && bu) || inw;
      if (mu)            dtag = "R11";
      else if (!has)     dtag = "R8";
      else if (!inw)     dtag = "R6";
      else if (pos == 0) dtag = nd ? "R4" : "R3";
      else               dtag = "R5";
      @(negedge clk);
      bclk_en = 0;
      s_valid = 0;
      check(dtag, {31'd0, ser_data}, {31'd0, eb});
      check("R2", {31'd0, ser_ws}, {31'd0, ews});
      check((!cp && bu) ? "R10" : "R9", {31'd0, sck_en}, {31'd0, esck});
      check("R8", {31'd0, underflow}, {31'd0, uf});
      @(negedge clk);
      check("R9", {31'd0, sck_en}, 32'd0);
    end
  endtask

  initial begin
    rst_n = 0; bclk_en = 0; s_valid = 0; s_data = '0;
    cfg_nodelay = 0; cfg_compress = 0; cfg_burst = 0;
    cfg_mute = 0; cfg_pad = 0; cfg_wlen = 5'd16;
    for (int nd = 0; nd < 2; nd++)
      for (int cp = 0; cp < 2; cp++) begin
        if (cp == 1 && nd == 0) continue;
        for (int bu = 0; bu < 2; bu++)
          for (int mu = 0; mu < 2; mu++)
            for (int pd = 0; pd < 2; pd++)
              for (int wi = 0; wi < 3; wi++)
                run_cfg(nd[0], cp[0], bu[0], mu[0], pd[0],
                        (wi == 0) ? 16 : (wi == 1) ? 11 : 1);
      end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule